// File: doc/BRIEF.md
# Lockable Pin-Function Select Bank

This block holds the function selection for a set of multi-purpose output pin groups. Two byte-wide configuration registers each carry four 2-bit select fields, one field per pin group, eight groups in all. Every field is decoded into a one-hot set of function enables that the pad logic uses to pick which internal source drives the pin. A select code that a group does not support is treated as the legacy function (code 0), so the reset state is the legacy pin arrangement.

An external lock input freezes both registers against writes, while reads keep returning the stored values. A hard reset always clears the bank. A soft power-state reset clears the bank only when the wake enable is low; with wake enabled the contents survive, so wake routing set up before a low-power state remains in place. Two derived outputs tell the pad logic which of two candidate pin groups carries the wake-event signal, and whether a shared data pin may be driven, which is allowed only once supply power is reported good.

Top module: `pinmux_cfg_bank`

## Requirements
- R1: A synchronous hard reset (rst_n low at a clock edge) clears both registers to 0 whatever the lock and wake-enable inputs are, so every group's function-0 enable is high (pin_fn_o reads 32'h1111_1111).
- R2: With lock_i low, a write (wr_en_i high) stores wdata_i into the register chosen by addr_i at the clock edge; address 0 holds groups 0 to 3 and address 1 holds groups 4 to 7, group n of a register in bits [2n+1:2n].
- R3: rdata_o returns, without a clock delay, the stored value of the register chosen by addr_i, including while lock_i is high.
- R4: While lock_i is high, writes to either register leave both registers and all decoded outputs unchanged.
- R5: A soft reset (soft_rst_i high at a clock edge) with wake_en_i low clears both registers to 0.
- R6: A soft reset with wake_en_i high leaves both registers unchanged.
- R7: For each group g, pin_fn_o[4g+k] is high exactly when the group's effective code equals k, so exactly one of the four bits of each group is high.
- R8: A code outside a group's supported set maps to the legacy code 0. With the default parameters the unsupported codes are: group 1 code 2, group 2 code 1, group 4 code 2, group 5 code 3, group 7 code 3; all others are supported.
- R9: wake_route_o[0] is high when group 3's effective code is 2; wake_route_o[1] is high when group 5's effective code is 2 and group 3's is not, so at most one bit is high and group 3 has priority.
- R10: data_oe_ok_o is high only when pwr_good_i is high and group 1's effective code is 1; it follows pwr_good_i with no clock delay.
- R11: When a soft reset and a write occur at the same edge, the clear wins if wake_en_i is low; if wake_en_i is high the write proceeds as in R2 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst_i | input | 1 | Synchronous soft power-state reset, active high |
| wake_en_i | input | 1 | Wake enable; when high the bank keeps its contents across a soft reset |
| lock_i | input | 1 | When high, register writes are ignored |
| pwr_good_i | input | 1 | Supply reported good; gates driving of the shared data pin |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 1 | Register select for both write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| pin_fn_o | output | 32 | Four one-hot function enables per group, group g in bits [4g+3:4g] |
| wake_route_o | output | 2 | Which candidate group carries the wake-event signal |
| data_oe_ok_o | output | 1 | Shared data pin may be driven as an output |

## Verification
The checker assumes that soft_rst_i, wake_en_i, lock_i and wr_en_i change only between clock edges and are at known levels whenever rst_n is high, and that a soft reset with wake enabled is not combined with a write when register stability is claimed. The bench drives every control from the falling edge, holds the bank in hard reset until the controls are defined, and keeps the soft-reset-with-write cases apart from the stability checks so each assertion's antecedent is met only where its claim applies. Combinational outputs such as rdata_o and data_oe_ok_o are sampled shortly after their inputs move, away from any clock edge.

// File: rtl/pinmux_cfg_pkg.sv
// Package: shared widths, types and helpers for the pin-function select bank.
// Assumes the legacy function is always encoded as code 0.
package pinmux_cfg_pkg;

    localparam int unsigned FIELD_W = 2;
    localparam int unsigned NUM_FN  = 1 << FIELD_W;

    typedef logic [FIELD_W-1:0] sel_code_t;
    typedef logic [NUM_FN-1:0]  fn_onehot_t;

    localparam sel_code_t LEGACY_CODE = '0;

    // Map an unsupported code onto the legacy function.
    function automatic sel_code_t legalize(sel_code_t code, fn_onehot_t legal_set);
        return (code == LEGACY_CODE || legal_set[code]) ? code : LEGACY_CODE;
    endfunction

    // Expand a code into a one-hot function enable vector.
    function automatic fn_onehot_t to_onehot(sel_code_t code);
        fn_onehot_t v;
        v = '0;
        v[code] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/pinmux_cfg_regs.sv
// Module: register storage for the select bank.
// Holds NUM_REGS registers of REG_W bits. Hard reset clears them; a soft
// reset clears them unless wake_en is high; writes are dropped while lock
// is high. Assumes all controls are synchronous to clk.
module pinmux_cfg_regs #(
    parameter int unsigned NUM_REGS = 2,
    parameter int unsigned REG_W    = 8,
    parameter int unsigned ADDR_W   = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      soft_rst,
    input  logic                      wake_en,
    input  logic                      lock,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [REG_W-1:0]          wr_data,
    output logic [REG_W-1:0]          rd_data,
    output logic [NUM_REGS*REG_W-1:0] cfg_flat
);

    logic [REG_W-1:0] regs_q [NUM_REGS];
    logic             addr_ok;

    // Purpose: flag addresses that name an existing register.
    always_comb addr_ok = (int'(addr) < NUM_REGS);

    // Purpose: reset, context-aware clear and lock-gated write of the bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else if (soft_rst && !wake_en) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else if (wr_en && !lock && addr_ok) begin
            regs_q[addr] <= wr_data;
        end
    end

    // Purpose: combinational read of the addressed register.
    always_comb rd_data = addr_ok ? regs_q[addr] : '0;

    // Purpose: flatten storage for the field decoders.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_flat
        assign cfg_flat[r*REG_W +: REG_W] = regs_q[r];
    end

endmodule

// File: rtl/pinmux_field_dec.sv
// Module: decoder for one pin group's select field.
// Unsupported codes (clear bits of LEGAL_SET) fall back to the legacy
// function; the result is a one-hot enable vector. Purely combinational.
module pinmux_field_dec
    import pinmux_cfg_pkg::*;
#(
    parameter fn_onehot_t LEGAL_SET = '1
) (
    input  sel_code_t  code_i,
    output fn_onehot_t fn_en_o
);

    sel_code_t eff_code;

    // Purpose: apply the supported-code set, then expand to one-hot.
    always_comb begin
        eff_code = legalize(code_i, LEGAL_SET);
        fn_en_o  = to_onehot(eff_code);
    end

endmodule

// File: rtl/pinmux_route.sv
// Module: derived pin routing flags.
// Picks which of two candidate groups carries the wake signal (group A
// has priority) and gates the shared data pin output on power-good.
// Assumes the hit inputs come from already-legalized decodes.
module pinmux_route (
    input  logic       wake_a_hit_i,
    input  logic       wake_b_hit_i,
    input  logic       data_hit_i,
    input  logic       pwr_good_i,
    output logic [1:0] wake_route_o,
    output logic       data_oe_ok_o
);

    // Purpose: priority-select the wake route, keep data pin an input until power is good.
    always_comb begin
        wake_route_o[0] = wake_a_hit_i;
        wake_route_o[1] = wake_b_hit_i && !wake_a_hit_i;
        data_oe_ok_o    = pwr_good_i && data_hit_i;
    end

endmodule

// File: rtl/pinmux_cfg_bank.sv
// Module: top of the lockable pin-function select bank.
// Stores the select registers, decodes each 2-bit field into one-hot
// function enables and derives wake routing and data-pin drive permission.
// Assumes a single address serves both read and write.
module pinmux_cfg_bank
    import pinmux_cfg_pkg::*;
#(
    parameter int unsigned NUM_REGS   = 2,
    parameter int unsigned REG_W      = 8,
    parameter logic [NUM_REGS*(REG_W/pinmux_cfg_pkg::FIELD_W)*pinmux_cfg_pkg::NUM_FN-1:0]
                           LEGAL_MASK = 32'h7F7B_FDBF,
    parameter int unsigned WAKE_GRP_A = 3,
    parameter int unsigned WAKE_GRP_B = 5,
    parameter int unsigned WAKE_CODE  = 2,
    parameter int unsigned DATA_GRP   = 1,
    parameter int unsigned DATA_CODE  = 1,
    localparam int unsigned FIELDS_PER_REG = REG_W / FIELD_W,
    localparam int unsigned NUM_GRP   = NUM_REGS * FIELDS_PER_REG,
    localparam int unsigned ADDR_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      soft_rst_i,
    input  logic                      wake_en_i,
    input  logic                      lock_i,
    input  logic                      pwr_good_i,
    input  logic                      wr_en_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [REG_W-1:0]          wdata_i,
    output logic [REG_W-1:0]          rdata_o,
    output logic [NUM_GRP*NUM_FN-1:0] pin_fn_o,
    output logic [1:0]                wake_route_o,
    output logic                      data_oe_ok_o
);

    logic [NUM_REGS*REG_W-1:0] cfg_flat;

    pinmux_cfg_regs #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst_i),
        .wake_en  (wake_en_i),
        .lock     (lock_i),
        .wr_en    (wr_en_i),
        .addr     (addr_i),
        .wr_data  (wdata_i),
        .rd_data  (rdata_o),
        .cfg_flat (cfg_flat)
    );

    // One decoder per pin group, each with its own supported-code set.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
        pinmux_field_dec #(
            .LEGAL_SET (LEGAL_MASK[g*NUM_FN +: NUM_FN])
        ) u_dec (
            .code_i  (cfg_flat[g*FIELD_W +: FIELD_W]),
            .fn_en_o (pin_fn_o[g*NUM_FN +: NUM_FN])
        );
    end

    pinmux_route u_route (
        .wake_a_hit_i (pin_fn_o[WAKE_GRP_A*NUM_FN + WAKE_CODE]),
        .wake_b_hit_i (pin_fn_o[WAKE_GRP_B*NUM_FN + WAKE_CODE]),
        .data_hit_i   (pin_fn_o[DATA_GRP*NUM_FN + DATA_CODE]),
        .pwr_good_i   (pwr_good_i),
        .wake_route_o (wake_route_o),
        .data_oe_ok_o (data_oe_ok_o)
    );

endmodule

// File: rtl/pinmux_cfg_bank_chk.sv
// Checker: temporal properties of the select bank, bound to the top.
// Assumes controls are stable between clock edges.
module pinmux_cfg_bank_chk #(
    parameter int unsigned NUM_GRP = 8,
    parameter int unsigned NUM_FN  = 4,
    parameter int unsigned CFG_W   = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      soft_rst_i,
    input logic                      wake_en_i,
    input logic                      lock_i,
    input logic                      wr_en_i,
    input logic                      pwr_good_i,
    input logic [NUM_GRP*NUM_FN-1:0] pin_fn_o,
    input logic [1:0]                wake_route_o,
    input logic                      data_oe_ok_o,
    input logic [CFG_W-1:0]          cfg_flat
);

    AST_HARD_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (cfg_flat == '0)); // R1

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && !(soft_rst_i && !wake_en_i)) |=> $stable(cfg_flat)); // R4

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_i && !wake_en_i) |=> (cfg_flat == '0)); // R5

    AST_SOFT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_i && wake_en_i && !wr_en_i) |=> $stable(cfg_flat)); // R6

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_onehot
        AST_FN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(pin_fn_o[g*NUM_FN +: NUM_FN]) == 1); // R7
    end

    AST_WAKE_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wake_route_o)); // R9

    AST_DATA_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good_i |-> !data_oe_ok_o); // R10

endmodule

bind pinmux_cfg_bank pinmux_cfg_bank_chk #(
    .NUM_GRP (NUM_GRP),
    .NUM_FN  (pinmux_cfg_pkg::NUM_FN),
    .CFG_W   (NUM_REGS*REG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst_i   (soft_rst_i),
    .wake_en_i    (wake_en_i),
    .lock_i       (lock_i),
    .wr_en_i      (wr_en_i),
    .pwr_good_i   (pwr_good_i),
    .pin_fn_o     (pin_fn_o),
    .wake_route_o (wake_route_o),
    .data_oe_ok_o (data_oe_ok_o),
    .cfg_flat     (cfg_flat)
);

// File: tb/pinmux_cfg_bank_tb.sv
// Bench: vector table for write/decode, then directed reset, lock,
// routing and soft-reset cases. Inputs move on the falling edge.
module pinmux_cfg_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n, soft_rst_i, wake_en_i, lock_i, pwr_good_i, wr_en_i;
    logic [0:0]  addr_i;
    logic [7:0]  wdata_i, rdata_o;
    logic [31:0] pin_fn_o;
    logic [1:0]  wake_route_o;
    logic        data_oe_ok_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    pinmux_cfg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .wake_en_i(wake_en_i),
        .lock_i(lock_i), .pwr_good_i(pwr_good_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_fn_o(pin_fn_o),
        .wake_route_o(wake_route_o), .data_oe_ok_o(data_oe_ok_o)
    );

    // {addr, write data, expected effective codes of the four groups}
    localparam logic [16:0] VEC [8] = '{
        {1'b0, 8'hE4, 8'hE4},
        {1'b0, 8'h1B, 8'h03},
        {1'b0, 8'hFF, 8'hFF},
        {1'b1, 8'hE4, 8'h24},
        {1'b1, 8'h1B, 8'h1B},
        {1'b1, 8'hAA, 8'hA8},
        {1'b1, 8'hFF, 8'h33},
        {1'b0, 8'h55, 8'h45}
    };

    function automatic logic [15:0] expand(logic [7:0] eff);
        logic [15:0] v;
        for (int k = 0; k < 4; k++) v[4*k +: 4] = 4'b0001 << eff[2*k +: 2];
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd_check(string req, logic a, logic [7:0] exp);
        addr_i = a;
        #1;
        check(req, {24'd0, rdata_o}, {24'd0, exp});
    endtask

    task automatic soft_pulse(logic with_wr, logic a, logic [7:0] d);
        @(negedge clk);
        soft_rst_i = 1'b1;
        wr_en_i = with_wr; addr_i = a; wdata_i = d;
        @(negedge clk);
        soft_rst_i = 1'b0; wr_en_i = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; soft_rst_i = 1'b0; wake_en_i = 1'b0; lock_i = 1'b0;
        pwr_good_i = 1'b1; wr_en_i = 1'b0; addr_i = 1'b0; wdata_i = '0;
        repeat (2) @(negedge clk);
        // R1: reset state
        rd_check("R1 reg0", 1'b0, 8'h00);
        rd_check("R1 reg1", 1'b1, 8'h00);
        check("R1 pin_fn", pin_fn_o, 32'h1111_1111);
        check("R9 reset route", {30'd0, wake_route_o}, 32'd0);
        check("R10 reset oe", {31'd0, data_oe_ok_o}, 32'd0);
        rst_n = 1'b1;

        // R2 R3 R7 R8: table of writes and decodes
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][16], VEC[i][15:8]);
            rd_check("R2 write/read", VEC[i][16], VEC[i][15:8]);
            check("R7 R8 decode",
                  {16'd0, VEC[i][16] ? pin_fn_o[31:16] : pin_fn_o[15:0]},
                  {16'd0, expand(VEC[i][7:0])});
        end

        // R4 R3: lock blocks writes, reads still work
        lock_i = 1'b1;
        wr(1'b0, 8'hE4);
        rd_check("R4 R3 locked reg0", 1'b0, 8'h55);
        wr(1'b1, 8'h00);
        rd_check("R4 R3 locked reg1", 1'b1, 8'hFF);
        check("R4 pin_fn upper", {16'd0, pin_fn_o[31:16]}, {16'd0, expand(8'h33)});
        lock_i = 1'b0;

        // R9: wake routing priority
        wr(1'b0, 8'h80);
        check("R9 route A", {30'd0, wake_route_o}, 32'd1);
        wr(1'b1, 8'h08);
        check("R9 route A priority", {30'd0, wake_route_o}, 32'd1);
        wr(1'b0, 8'h00);
        check("R9 route B", {30'd0, wake_route_o}, 32'd2);
        wr(1'b1, 8'h0C);
        check("R8 R9 illegal no route", {30'd0, wake_route_o}, 32'd0);

        // R10: data pin drive gated by power-good
        wr(1'b0, 8'h04);
        check("R10 oe powered", {31'd0, data_oe_ok_o}, 32'd1);
        pwr_good_i = 1'b0;
        #1;
        check("R10 oe no power", {31'd0, data_oe_ok_o}, 32'd0);
        pwr_good_i = 1'b1;
        wr(1'b0, 8'h08);
        check("R8 R10 illegal code oe", {31'd0, data_oe_ok_o}, 32'd0);

        // R6: soft reset keeps context with wake enabled
        wake_en_i = 1'b1;
        soft_pulse(1'b0, 1'b0, 8'h00);
        rd_check("R6 keep reg0", 1'b0, 8'h08);
        rd_check("R6 keep reg1", 1'b1, 8'h0C);
        // R11: write alongside kept soft reset
        soft_pulse(1'b1, 1'b1, 8'h1B);
        rd_check("R11 write with wake", 1'b1, 8'h1B);

        // R5: soft reset clears with wake disabled
        wake_en_i = 1'b0;
        soft_pulse(1'b0, 1'b0, 8'h00);
        rd_check("R5 clear reg0", 1'b0, 8'h00);
        rd_check("R5 clear reg1", 1'b1, 8'h00);
        check("R5 pin_fn", pin_fn_o, 32'h1111_1111);
        // R11: clear beats write
        soft_pulse(1'b1, 1'b0, 8'hFF);
        rd_check("R11 clear wins", 1'b0, 8'h00);

        // R1: hard reset clears despite lock and wake enable
        wr(1'b0, 8'hE4);
        wr(1'b1, 8'h1B);
        @(negedge clk);
        lock_i = 1'b1; wake_en_i = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        rd_check("R1 hard reg0", 1'b0, 8'h00);
        rd_check("R1 hard reg1", 1'b1, 8'h00);
        rst_n = 1'b1; lock_i = 1'b0; wake_en_i = 1'b0;
        @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule